// File: doc/BRIEF.md
# Line Alarm Interrupt Status Controller

This block gathers alarm conditions from a line transceiver and raises one interrupt line toward a host processor. Five alarm inputs are levels: loss of signal, network loopback, alarm indication signal, test-pattern sync and driver failure open. Each of them is brought into the clock domain through a synchronizer and compared against a reference copy of its own level. Any departure from that reference is latched as a transition. Two further inputs are single-cycle pulses from an elastic store, one for overflow and one for underflow. Each pulse sets a sticky flag.

The host reaches two byte-wide registers over a plain address/data bus. A read/write clear/mask register holds one bit per source. Writing a 1 to a bit discards that source's pending event, and the 1 keeps the source masked for as long as it stays there. Writing a 0 enables the source. A read-only transition status register shows the latched events. Reading it clears the two elastic store flags. The interrupt output is a registered OR of every status bit whose mask bit is 0.

The bit layout from bit 0 upward is: loss of signal, network loopback, alarm indication signal, pattern sync, a reserved position, driver failure open, elastic store overflow, elastic store underflow. The same positions are used in both registers.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The clear/mask register is selected when address bits 6..1 equal 6'b010011, and the status register when they equal 6'b010100. Bits 7 and 0 are ignored. Any other address reads 0x00 and a write to it changes nothing.
- R2: Reset sets the clear/mask register to 0xFF. All eight of its bits can be written and read back.
- R3: The status bit of a level alarm becomes 1 three clock edges after its input changes from the reference level. It stays 1 even if the input returns to the reference level.
- R4: Writing a 1 to a level alarm's clear/mask bit zeroes its status bit at that edge and takes the present synchronized level as the new reference. Writing a 0 leaves the status bit unchanged.
- R5: Source-to-bit mapping: alarm inputs 0..3 map to status bits 0..3, alarm input 4 (driver open) maps to bit 5, overflow maps to bit 6 and underflow maps to bit 7.
- R6: An overflow or underflow pulse sets its status bit, which is visible at the next cycle. A read of the status register clears both bits at that edge. Writing a 1 to bit 6 or bit 7 of the clear/mask register also clears that bit.
- R7: If a pulse arrives in the same cycle as a read or clear of its bit, the pulse wins and the bit is 1 afterwards.
- R8: Status bit 4 always reads 0.
- R9: irq is the OR of the status bits whose clear/mask bit is 0, delayed by one register. It is active high.
- R10: After reset the status register reads 0x00 and irq is 0. Inputs that stay steady through and after reset report no transition.
- R11: A masked source still records its transition in the status register but does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data for the addressed register, same cycle |
| lvl_alarm | input | 5 | Level alarms: [0] signal loss, [1] network loopback, [2] alarm indication, [3] pattern sync, [4] driver open |
| es_ovf | input | 1 | Elastic store overflow pulse |
| es_unf | input | 1 | Elastic store underflow pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two operations on the same status bit can land in one cycle: a new elastic store event and a host read or clear of that bit. Likewise, a level change can coincide with a clear write. The bench provokes the first case directly, pulsing underflow during a status read and then reading again. In the random phase it keeps reads, clear writes, pulses and level toggles overlapping freely. Every cycle is judged against a bench-side model in which the event takes precedence and a clear takes a new reference level.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int REG_W      = 8;
    localparam int N_LVL      = 5;
    localparam int N_EVT      = 2;
    localparam int RSV_BIT    = 4;
    localparam int EVT_BASE   = 6;
    localparam logic [5:0] SEL_CLRMASK = 6'b010011;
    localparam logic [5:0] SEL_STATUS  = 6'b010100;

    // Status/mask bit position of level alarm i (skips the reserved bit)
    function automatic int lvl_pos(input int i);
        return (i < RSV_BIT) ? i : i + 1;
    endfunction
endpackage

// File: rtl/alarm_bus_regs.sv
// alarm_bus_regs: address decode, clear/mask register and read mux.
// Assumes single-cycle strobes; address bits 7 and 0 are ignored.
// Outputs clear strobes (write data gated by a clear/mask write).
module alarm_bus_regs #(
    parameter int         DW       = 8,
    parameter logic [5:0] CLR_SEL  = 6'b010011,
    parameter logic [5:0] STAT_SEL = 6'b010100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] stat,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] clr_stb,
    output logic          stat_rd,
    output logic [DW-1:0] rdata
);
    logic hit_clr;
    logic hit_stat;

    // Decode the six significant address bits
    always_comb begin
        hit_clr  = (addr[6:1] == CLR_SEL);
        hit_stat = (addr[6:1] == STAT_SEL);
    end

    // Clear strobes and status-read strobe toward the status logic
    always_comb begin
        clr_stb = (wr && hit_clr) ? wdata : '0;
        stat_rd = rd && hit_stat;
    end

    // Clear/mask register storage, all masked at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr && hit_clr)
            mask_q <= wdata;
    end

    // Read data selection
    always_comb begin
        if (hit_clr)
            rdata = mask_q;
        else if (hit_stat)
            rdata = stat;
        else
            rdata = '0;
    end
endmodule

// File: rtl/level_change_det.sv
// level_change_det: per-alarm synchronizer, reference level and
// transition latch. Assumes SYNC >= 2. During reset the synchronizer
// and the reference both load the raw input, so a steady input
// reports nothing after reset.
module level_change_det #(
    parameter int N    = 5,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] chg
);
    for (genvar g = 0; g < N; g++) begin : g_lvl
        logic [SYNC-1:0] sh;
        logic            ref_lvl;
        logic            chg_q;

        // Synchronize, track reference, latch departure from reference
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh      <= {SYNC{lvl_in[g]}};
                ref_lvl <= lvl_in[g];
                chg_q   <= 1'b0;
            end else begin
                sh <= {sh[SYNC-2:0], lvl_in[g]};
                if (clr[g]) begin
                    ref_lvl <= sh[SYNC-1];
                    chg_q   <= 1'b0;
                end else if (sh[SYNC-1] != ref_lvl) begin
                    chg_q   <= 1'b1;
                end
            end
        end

        assign chg[g] = chg_q;
    end
endmodule

// File: rtl/es_sticky_bits.sv
// es_sticky_bits: sticky flags for pulse-type elastic store events.
// Assumes event pulses are synchronous to clk. A new event beats any
// clear in the same cycle.
module es_sticky_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic         rd_clr,
    output logic [N-1:0] sticky
);
    // Set on event, otherwise clear on status read or clear write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (evt[i])
                    sticky[i] <= 1'b1;
                else if (rd_clr || clr[i])
                    sticky[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_reg.sv
// irq_reg: registered OR of unmasked status bits. Active high.
module irq_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] stat,
    input  logic [DW-1:0] mask,
    output logic          irq
);
    // Register the interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(stat & ~mask);
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// alarm_irq_ctrl: line alarm interrupt and status controller (top).
// Assumes all inputs except lvl_alarm are synchronous to clk.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [N_LVL-1:0] lvl_alarm,
    input  logic             es_ovf,
    input  logic             es_unf,
    output logic             irq
);
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] clr_stb;
    logic [REG_W-1:0] stat_vec;
    logic             stat_rd;
    logic [N_LVL-1:0] lvl_clr;
    logic [N_LVL-1:0] lvl_chg;
    logic [N_EVT-1:0] es_flag;

    alarm_bus_regs #(
        .DW(REG_W), .CLR_SEL(SEL_CLRMASK), .STAT_SEL(SEL_STATUS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rd(bus_rd), .stat(stat_vec), .mask_q(mask_q),
        .clr_stb(clr_stb), .stat_rd(stat_rd), .rdata(bus_rdata)
    );

    // Route clear strobes to level alarm positions
    always_comb begin
        for (int i = 0; i < N_LVL; i++)
            lvl_clr[i] = clr_stb[lvl_pos(i)];
    end

    level_change_det #(.N(N_LVL), .SYNC(SYNC)) u_lvl (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_alarm),
        .clr(lvl_clr), .chg(lvl_chg)
    );

    es_sticky_bits #(.N(N_EVT)) u_es (
        .clk(clk), .rst_n(rst_n), .evt({es_unf, es_ovf}),
        .clr(clr_stb[EVT_BASE +: N_EVT]), .rd_clr(stat_rd),
        .sticky(es_flag)
    );

    // Assemble the status view; the reserved bit stays 0
    always_comb begin
        stat_vec = '0;
        for (int i = 0; i < N_LVL; i++)
            stat_vec[lvl_pos(i)] = lvl_chg[i];
        stat_vec[EVT_BASE +: N_EVT] = es_flag;
    end

    irq_reg #(.DW(REG_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat(stat_vec), .mask(mask_q), .irq(irq)
    );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
// alarm_irq_ctrl_chk: temporal checks on the controller, bound below.
module alarm_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wr,
    input logic       rd,
    input logic       es_ovf,
    input logic       es_unf,
    input logic [7:0] mask_q,
    input logic [7:0] stat,
    input logic       irq
);
    logic clr_wr;
    logic st_rd;

    // Independent decode of bus strobes
    always_comb begin
        clr_wr = wr && (addr[6:1] == 6'b010011);
        st_rd  = rd && (addr[6:1] == 6'b010100);
    end

    assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & ~mask_q)) |=> irq);
    assert_irq_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & ~mask_q)) |=> !irq);
    assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        es_ovf |=> stat[6]);
    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !es_ovf && !es_unf) |=> (stat[7:6] == 2'b00));
    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && es_unf) |=> stat[7]);
    assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[4]);
    assert_clear_los_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wdata[0]) |=> !stat[0]);
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (mask_q == $past(wdata)));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .es_ovf(es_ovf), .es_unf(es_unf),
    .mask_q(mask_q), .stat(stat_vec), .irq(irq)
);

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [7:0] addr, wdata;
    logic       wr, rd, ovf, unf;
    logic [4:0] lvl;
    logic [7:0] rdata;
    logic       irq;
    int checks = 0;
    int errors = 0;

    localparam logic [7:0] A_CLR  = 8'h26;
    localparam logic [7:0] A_STAT = 8'h28;

    alarm_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .lvl_alarm(lvl),
        .es_ovf(ovf), .es_unf(unf), .irq(irq)
    );

    // Reference model state
    logic [4:0] m_s1, m_s2, m_ref;
    logic [7:0] m_stat, m_mask;
    logic       m_irq;

    function automatic int bpos(input int i);
        return (i < 4) ? i : 5;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a[6:1] == 6'b010011) return m_mask;
        if (a[6:1] == 6'b010100) return m_stat;
        return 8'h00;
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] ns;
        logic       cw, sr, ev;
        if (!rst_n) begin
            m_s1 = lvl; m_s2 = lvl; m_ref = lvl;
            m_stat = 8'h00; m_mask = 8'hFF; m_irq = 1'b0;
        end else begin
            cw = wr && (addr[6:1] == 6'b010011);
            sr = rd && (addr[6:1] == 6'b010100);
            ns = m_stat;
            for (int i = 0; i < 5; i++) begin
                if (cw && wdata[bpos(i)]) begin
                    m_ref[i] = m_s2[i];
                    ns[bpos(i)] = 1'b0;
                end else if (m_s2[i] != m_ref[i]) begin
                    ns[bpos(i)] = 1'b1;
                end
            end
            for (int b = 6; b < 8; b++) begin
                ev = (b == 6) ? ovf : unf;
                if (ev) ns[b] = 1'b1;
                else if (sr || (cw && wdata[b])) ns[b] = 1'b0;
            end
            m_irq = |(m_stat & ~m_mask);
            m_stat = ns;
            if (cw) m_mask = wdata;
            m_s2 = m_s1;
            m_s1 = lvl;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    // Drive one cycle of bus/event inputs at the falling edge
    task automatic step(input logic [7:0] a, input logic [7:0] d,
                        input logic w, input logic r,
                        input logic o, input logic u);
        @(negedge clk);
        addr = a; wdata = d; wr = w; rd = r; ovf = o; unf = u;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(8'h00, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        step(a, 8'h00, 0, 1, 0, 0);
        v = rdata;
    endtask

    initial begin : watchdog
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        addr = 0; wdata = 0; wr = 0; rd = 0; ovf = 0; unf = 0;
        lvl = 5'b00101; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        // R10 / R2 reset state
        rd_reg(A_CLR, v);  chk("R2 reset mask", v, 8'hFF);
        chk("R10 irq after reset", {7'b0, irq}, 8'h00);
        rd_reg(A_STAT, v); chk("R10 status after reset", v, 8'h00);
        // R1 decode and ignored bits
        rd_reg(8'hA7, v);  chk("R1 A7/A0 ignored", v, 8'hFF);
        rd_reg(8'h30, v);  chk("R1 other address reads 0", v, 8'h00);
        step(8'h30, 8'h00, 1, 0, 0, 0);
        rd_reg(A_CLR, v);  chk("R1 other address write ignored", v, 8'hFF);
        step(8'hA7, 8'h5A, 1, 0, 0, 0);
        rd_reg(A_CLR, v);  chk("R2 mask readback", v, 8'h5A);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        // R3 level transition on LOS, then return
        @(negedge clk); lvl[0] = 1'b0; #1;
        idle(2);
        rd_reg(A_STAT, v); chk("R3 LOS status after 3 edges", v, 8'h01);
        chk("R9 irq one cycle later still 0", {7'b0, irq}, 8'h00);
        idle(1);
        chk("R9 irq raised", {7'b0, irq}, 8'h01);
        @(negedge clk); lvl[0] = 1'b1; #1;
        idle(5);
        rd_reg(A_STAT, v); chk("R3 status holds after return", v, 8'h01);
        // R4 clear with 1
        step(A_CLR, 8'h11, 1, 0, 0, 0);
        rd_reg(A_STAT, v); chk("R4 clear zeroes status", v, 8'h00);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        idle(4);
        rd_reg(A_STAT, v); chk("R4 new reference, no transition", v, 8'h00);
        // R4 write 0 keeps status
        @(negedge clk); lvl[1] = 1'b1; #1;
        idle(4);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        rd_reg(A_STAT, v); chk("R4 write 0 keeps status", v, 8'h02);
        step(A_CLR, 8'h12, 1, 0, 0, 0);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        // R5 mapping of alarm 3 and alarm 4
        @(negedge clk); lvl[3] = 1'b1; lvl[4] = 1'b1; #1;
        idle(4);
        rd_reg(A_STAT, v); chk("R5 pattern sync bit3, driver open bit5", v, 8'h28);
        step(A_CLR, 8'h38, 1, 0, 0, 0);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        idle(3);
        // R6 sticky events
        step(8'h00, 8'h00, 0, 0, 1, 0);
        rd_reg(A_STAT, v); chk("R6 overflow sets bit6", v, 8'h40);
        rd_reg(A_STAT, v); chk("R6 read clears", v, 8'h00);
        step(8'h00, 8'h00, 0, 0, 0, 1);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        rd_reg(A_STAT, v); chk("R6 underflow sets bit7", v, 8'h80);
        step(A_CLR, 8'h90, 1, 0, 0, 0);
        rd_reg(A_STAT, v); chk("R6 clear write clears bit7", v, 8'h00);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        // R7 event during read wins
        step(A_STAT, 8'h00, 0, 1, 0, 1);
        rd_reg(A_STAT, v); chk("R7 event beats read", v, 8'h80);
        rd_reg(A_STAT, v); chk("R7 next read clears", v, 8'h00);
        // R8 reserved bit with every source active
        @(negedge clk); lvl = ~lvl; ovf = 1'b1; unf = 1'b1; #1;
        idle(4);
        rd_reg(A_STAT, v); chk("R8 all sources, bit4 zero", v, 8'hEF);
        // R11 masked source records but no irq
        step(A_CLR, 8'hFF, 1, 0, 0, 0);
        idle(2);
        @(negedge clk); lvl[2] = ~lvl[2]; #1;
        idle(4);
        rd_reg(A_STAT, v); chk("R11 masked source recorded", v, 8'h04);
        chk("R11 masked irq low", {7'b0, irq}, 8'h00);
        step(A_CLR, 8'h10, 1, 0, 0, 0);
        idle(1);
        chk("R9 irq lags unmask", {7'b0, irq}, 8'h00);
        idle(1);
        chk("R9 irq after unmask", {7'b0, irq}, 8'h01);
        // Random phase checked against the model
        void'($urandom(32'h1234));
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic [2:0] sel;
            sel = 3'($urandom % 8);
            a = (sel < 3) ? A_CLR : (sel < 6) ? A_STAT : 8'($urandom);
            a[7] = 1'($urandom); a[0] = 1'($urandom);
            @(negedge clk);
            addr = a; wdata = 8'($urandom);
            wr = ($urandom % 8) == 0; rd = ($urandom % 4) == 0;
            ovf = ($urandom % 16) == 0; unf = ($urandom % 16) == 0;
            for (int i = 0; i < 5; i++)
                if (($urandom % 24) == 0) lvl[i] = ~lvl[i];
            #1;
            chk("R5 R6 R7 random read data", rdata, exp_rd(a));
            chk("R9 random irq", {7'b0, irq}, {7'b0, m_irq});
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule